// File: doc/BRIEF.md
# Serial Receiver with Error Tagging

This block recovers characters from an asynchronous serial line. It oversamples the line with a tick that runs at sixteen times the bit rate. It qualifies each start bit and collects 5 to 8 data bits, least significant first. An optional parity bit follows, and then the stop bit. Every finished character is presented on a single-cycle write port as a 12-bit entry. The entry holds the data in the low byte and four error flags above it, ready to be pushed into an external receive buffer.

The block also keeps a four-bit error-status register. The framing, parity and break bits of this register change only when the surrounding logic reports that an entry has been read from the buffer. They then show that entry's flags. The overrun bit is set as soon as a character is lost to a full buffer. A clear pulse or reset empties all four bits. An active-low request-to-send output can be tied to buffer occupancy so that a remote transmitter holds off while the buffer has no room.

Top module: `uart_rx_status`

## Requirements
- R1: `len_sel` selects the character length as 00=5, 01=6, 10=7 and 11=8 bits. Bits arrive least significant first. The entry's bits [7:0] carry the data, zero-extended above the chosen length.
- R2: A low line seen on a tick is a start candidate. It is accepted only if the line is still low on the 8th tick, counting the detecting tick as the first. A shorter low pulse produces no entry. Each later bit is sampled 16 ticks after the previous sample.
- R3: With `par_on`=1, a parity bit follows the data. The expected parity bit is 0 when `par_fix`=1 and `par_even`=1, and 1 when `par_fix`=1 and `par_even`=0. When `par_fix`=0, it is the bit that makes the count of ones in data plus parity even (`par_even`=1) or odd (`par_even`=0). A mismatch sets entry bit [9].
- R4: A stop bit sampled low sets entry bit [8]. Only the first stop bit is sampled, so a transmitter that sends two stop bits is received without error.
- R5: If every sample of a frame is low, including the data, parity and stop samples, the entry is exactly 0x500: data 0, break flag [10]=1, framing flag [8]=1 and parity flag [9]=0. No new start is searched for until the line has been seen high.
- R6: A character that finishes while `buf_full`=1 is discarded, and no write occurs. Status bit [3] is set on the next clock. Entry bit [11] is set on the next entry that is written, and on no later entry.
- R7: On `rd_pulse`, status bits [0] framing, [1] parity and [2] break take the values of `rd_err` [0], [1] and [2]. At all other times these bits keep their value, and receiving a character does not change them. Reads do not affect status bit [3].
- R8: A `clr_pulse` clears all four status bits on the next clock, and it wins over a read or an overrun in the same cycle. Reset also clears them.
- R9: While idle with `rx_on`=0, the line is ignored and no entry is produced. Dropping `rx_on` during a character still lets that character finish and be written.
- R10: `rts_n` is a register that is high on the clock after `flow_on`=1 and `buf_full`=1, and low otherwise.
- R11: After reset, `wr_valid`=0, `status`=0 and `rts_n`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Character length code |
| par_on | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_fix | input | 1 | Fixed-value parity select |
| rx_on | input | 1 | Receiver enable |
| flow_on | input | 1 | Request-to-send flow control enable |
| buf_full | input | 1 | Receive buffer has no room |
| rd_pulse | input | 1 | An entry is being read from the buffer |
| rd_err | input | 3 | Break, parity, framing flags of that entry ([2:0]) |
| clr_pulse | input | 1 | Clear the error-status register |
| wr_valid | output | 1 | Entry write strobe |
| wr_entry | output | 12 | Entry: flags [11:8], data [7:0] |
| status | output | 4 | Overrun, break, parity, framing ([3:0]) |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions take `tick16` to be a single-cycle pulse with at least a few clocks between pulses. They take the line and the configuration to be steady across each tick period, and the line-control inputs to be held for the whole of a character. The stimulus produces ticks from a fixed divide-by-four counter. It changes `rxd` one time unit after a tick edge and alters the configuration only between frames. It therefore stays inside those assumptions while it varies length, parity mode, parity faults, stop-bit count, buffer state and enable timing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W  = 8;
  localparam int ENTRY_W = 12;
  localparam int FE_POS  = 8;
  localparam int PE_POS  = 9;
  localparam int BE_POS  = 10;
  localparam int OV_POS  = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_on;
    logic       par_even;
    logic       par_fix;
  } line_cfg_t;

  // number of data bits for a length code
  function automatic logic [3:0] bits_for_len(input logic [1:0] len);
    return {2'b00, len} + 4'd5;
  endfunction

  // bits enter at the top of the shifter; move them down to bit 0
  function automatic logic [DATA_W-1:0] align_data(input logic [DATA_W-1:0] sh,
                                                   input logic [1:0] len);
    logic [3:0] gap;
    gap = 4'd8 - bits_for_len(len);
    return sh >> gap;
  endfunction

  // parity bit a correct transmitter sends for this data
  function automatic logic want_parity(input logic [DATA_W-1:0] d,
                                       input logic even,
                                       input logic fixed);
    logic ones_odd;
    ones_odd = ^d;
    if (fixed) return ~even;
    return even ? ones_odd : ~ones_odd;
  endfunction

  function automatic logic [ENTRY_W-1:0] pack_entry(input logic ov,
                                                    input logic be,
                                                    input logic pe,
                                                    input logic fe,
                                                    input logic [DATA_W-1:0] d);
    return {ov, be, pe, fe, d};
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              rx_on,
  input  line_cfg_t         cfg,
  output logic              chr_done,
  output logic [DATA_W-1:0] chr_data,
  output logic              chr_fe,
  output logic              chr_pe,
  output logic              chr_be
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] BIT_LAST   = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] START_LAST = CW'(OVERSAMPLE / 2 - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [3:0]        bidx;
  logic [DATA_W-1:0] sh;
  logic              any_hi;
  logic              par_bad;
  line_cfg_t         cfg_q;

  logic [3:0]        nbits;
  logic [DATA_W-1:0] cur_data;
  logic              mid_bit;
  logic              start_hit;
  logic              start_ok;
  logic              stop_hit;
  logic              brk_now;

  assign nbits     = bits_for_len(cfg_q.len);
  assign cur_data  = align_data(sh, cfg_q.len);
  assign mid_bit   = tick && (cnt == BIT_LAST);
  assign start_hit = tick && (state == ST_START) && (cnt == START_LAST);
  assign start_ok  = start_hit && !line;
  assign stop_hit  = mid_bit && (state == ST_STOP);
  assign brk_now   = !any_hi && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      sh       <= '0;
      any_hi   <= 1'b0;
      par_bad  <= 1'b0;
      cfg_q    <= '0;
      chr_done <= 1'b0;
      chr_data <= '0;
      chr_fe   <= 1'b0;
      chr_pe   <= 1'b0;
      chr_be   <= 1'b0;
    end else begin
      chr_done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (rx_on && !line) begin
              state <= ST_START;
              cnt   <= CW'(1);
              cfg_q <= cfg;
            end
          end
          ST_START: begin
            if (start_hit) begin
              if (start_ok) begin
                state   <= ST_DATA;
                cnt     <= '0;
                bidx    <= '0;
                sh      <= '0;
                any_hi  <= 1'b0;
                par_bad <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_DATA: begin
            if (mid_bit) begin
              sh     <= {line, sh[DATA_W-1:1]};
              any_hi <= any_hi | line;
              cnt    <= '0;
              if (bidx == nbits - 4'd1) state <= cfg_q.par_on ? ST_PAR : ST_STOP;
              else                      bidx  <= bidx + 4'd1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_PAR: begin
            if (mid_bit) begin
              par_bad <= (line != want_parity(cur_data, cfg_q.par_even, cfg_q.par_fix));
              any_hi  <= any_hi | line;
              cnt     <= '0;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_STOP: begin
            if (stop_hit) begin
              chr_done <= 1'b1;
              chr_fe   <= !line;
              chr_be   <= brk_now;
              chr_pe   <= brk_now ? 1'b0 : par_bad;
              chr_data <= brk_now ? '0 : cur_data;
              cnt      <= '0;
              state    <= line ? ST_IDLE : ST_WAITHI;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_WAITHI: begin
            if (line) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rx_on) |=> (state == ST_IDLE));

  // R5
  brk_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && chr_be) |-> (chr_fe && !chr_pe && chr_data == '0));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |=> !chr_done);

  // R4
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && line) |=> (state == ST_IDLE && !chr_fe));
endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_pulse,
  input  logic [2:0] rd_err,
  input  logic       clr_pulse,
  input  logic       ovr_event,
  output logic [3:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (clr_pulse) begin
      stat <= '0;
    end else begin
      if (rd_pulse)  stat[2:0] <= rd_err;
      if (ovr_event) stat[3]   <= 1'b1;
    end
  end

  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (stat == 4'd0));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pulse && !clr_pulse) |=> $stable(stat[2:0]));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[3] && !clr_pulse) |=> stat[3]);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         rxd,
  input  logic [1:0]   len_sel,
  input  logic         par_on,
  input  logic         par_even,
  input  logic         par_fix,
  input  logic         rx_on,
  input  logic         flow_on,
  input  logic         buf_full,
  input  logic         rd_pulse,
  input  logic [2:0]   rd_err,
  input  logic         clr_pulse,
  output logic         wr_valid,
  output logic [11:0]  wr_entry,
  output logic [3:0]   status,
  output logic         rts_n
);
  logic              line_s;
  line_cfg_t         cfg;
  logic              chr_done;
  logic [DATA_W-1:0] chr_data;
  logic              chr_fe;
  logic              chr_pe;
  logic              chr_be;
  logic              ovr_pend;
  logic              ovr_event;
  logic              store_now;

  assign cfg = '{len: len_sel, par_on: par_on, par_even: par_even, par_fix: par_fix};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line_s)
  );

  uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .line     (line_s),
    .rx_on    (rx_on),
    .cfg      (cfg),
    .chr_done (chr_done),
    .chr_data (chr_data),
    .chr_fe   (chr_fe),
    .chr_pe   (chr_pe),
    .chr_be   (chr_be)
  );

  assign ovr_event = chr_done && buf_full;
  assign store_now = chr_done && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_entry <= '0;
      ovr_pend <= 1'b0;
      rts_n    <= 1'b0;
    end else begin
      wr_valid <= store_now;
      rts_n    <= flow_on && buf_full;
      if (store_now) begin
        wr_entry <= pack_entry(ovr_pend, chr_be, chr_pe, chr_fe, chr_data);
        ovr_pend <= 1'b0;
      end else if (ovr_event) begin
        ovr_pend <= 1'b1;
      end
    end
  end

  uart_rx_errstat u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pulse  (rd_pulse),
    .rd_err    (rd_err),
    .clr_pulse (clr_pulse),
    .ovr_event (ovr_event),
    .stat      (status)
  );

  // R6
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_event && !clr_pulse) |=> (status[3] && !wr_valid));

  // R6
  ovr_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_entry[OV_POS]) |=> !ovr_pend);

  // R10
  rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_on && buf_full) |=> rts_n);

  // R10
  rts_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_full |=> !rts_n);
endmodule

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick16 = 1'b0;
  logic [1:0]  tdiv = 2'd0;
  logic        rxd = 1'b1;
  logic [1:0]  len_sel = 2'b11;
  logic        par_on = 1'b0;
  logic        par_even = 1'b0;
  logic        par_fix = 1'b0;
  logic        rx_on = 1'b1;
  logic        flow_on = 1'b0;
  logic        buf_full = 1'b0;
  logic        rd_pulse = 1'b0;
  logic [2:0]  rd_err = 3'b000;
  logic        clr_pulse = 1'b0;
  logic        wr_valid;
  logic [11:0] wr_entry;
  logic [3:0]  status;
  logic        rts_n;

  int checks = 0;
  int failures = 0;
  logic [11:0] obs_q[$];

  uart_rx_status u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .len_sel(len_sel),
    .par_on(par_on), .par_even(par_even), .par_fix(par_fix), .rx_on(rx_on),
    .flow_on(flow_on), .buf_full(buf_full), .rd_pulse(rd_pulse), .rd_err(rd_err),
    .clr_pulse(clr_pulse), .wr_valid(wr_valid), .wr_entry(wr_entry),
    .status(status), .rts_n(rts_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  always @(negedge clk) begin
    if (rst_n && wr_valid) obs_q.push_back(wr_entry);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] l);
    return int'(l) + 5;
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] l,
                                   input logic ev, input logic fx);
    int ones = 0;
    for (int i = 0; i < nbits_of(l); i++) ones += int'(d[i]);
    if (fx) return ev ? 1'b0 : 1'b1;
    if (ev) return (ones % 2 == 1);
    return (ones % 2 == 0);
  endfunction

  function automatic logic [11:0] exp_word(input logic [7:0] d, input logic [1:0] l,
                                           input logic ov, input logic be,
                                           input logic pe, input logic fe);
    logic [7:0] m;
    m = 8'hFF >> (8 - nbits_of(l));
    return {ov, be, pe, fe, d & m};
  endfunction

  task automatic on_tick();
    @(posedge clk iff tick16);
    #1;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    for (int i = 0; i < n; i++) on_tick();
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par,
                      input logic stop_v, input int nstop);
    on_tick();
    hold(1'b0, 16);
    for (int i = 0; i < nbits_of(len_sel); i++) hold(d[i], 16);
    if (par_on) hold(par_bit(d, len_sel, par_even, par_fix) ^ bad_par, 16);
    hold(stop_v, 16);
    for (int i = 1; i < nstop; i++) hold(1'b1, 16);
    hold(1'b1, 6);
  endtask

  task automatic expect_entry(input logic [11:0] e, input string req);
    if (obs_q.size() == 0) chk(1'b0, req, 32'hFFFF_FFFF, {20'd0, e});
    else begin
      logic [11:0] got;
      got = obs_q.pop_front();
      chk(got == e, req, {20'd0, got}, {20'd0, e});
    end
  endtask

  task automatic expect_none(input string req);
    chk(obs_q.size() == 0, req, obs_q.size(), 0);
    obs_q.delete();
  endtask

  task automatic do_read(input logic [2:0] err, input logic clr);
    @(posedge clk); #1;
    rd_pulse = 1'b1; rd_err = err; clr_pulse = clr;
    @(posedge clk); #1;
    rd_pulse = 1'b0; clr_pulse = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1;
    // R11 reset state
    chk(wr_valid == 1'b0, "R11 wr_valid", wr_valid, 0);
    chk(status == 4'd0, "R11 status", status, 0);
    chk(rts_n == 1'b0, "R11 rts_n", rts_n, 0);
    rst_n = 1'b1;
    hold(1'b1, 4);

    // R1 8-bit, no parity
    len_sel = 2'b11; par_on = 0;
    send(8'hA5, 0, 1, 1);
    expect_entry(exp_word(8'hA5, 2'b11, 0, 0, 0, 0), "R1 len8");
    // R1 5-bit with upper bits ignored
    len_sel = 2'b00;
    send(8'hF6, 0, 1, 1);
    expect_entry(exp_word(8'hF6, 2'b00, 0, 0, 0, 0), "R1 len5");

    // R3 even parity good and bad, fixed parity
    len_sel = 2'b10; par_on = 1; par_even = 1; par_fix = 0;
    send(8'h3B, 0, 1, 1);
    expect_entry(exp_word(8'h3B, 2'b10, 0, 0, 0, 0), "R3 even good");
    send(8'h3B, 1, 1, 1);
    expect_entry(exp_word(8'h3B, 2'b10, 0, 0, 1, 0), "R3 even bad");
    par_fix = 1; par_even = 0;
    send(8'h11, 0, 1, 1);
    expect_entry(exp_word(8'h11, 2'b10, 0, 0, 0, 0), "R3 fixed one");
    par_fix = 0; par_on = 0; len_sel = 2'b11;

    // R2 short low pulse rejected
    on_tick(); hold(1'b0, 4); hold(1'b1, 40);
    expect_none("R2 glitch");

    // R4 framing error and two stop bits
    send(8'h5A, 0, 0, 1);
    hold(1'b1, 16);
    expect_entry(exp_word(8'h5A, 2'b11, 0, 0, 0, 1), "R4 framing");
    send(8'hC3, 0, 1, 2);
    send(8'h3C, 0, 1, 2);
    expect_entry(exp_word(8'hC3, 2'b11, 0, 0, 0, 0), "R4 two stop a");
    expect_entry(exp_word(8'h3C, 2'b11, 0, 0, 0, 0), "R4 two stop b");

    // R5 break
    par_on = 1; par_even = 0;
    on_tick(); hold(1'b0, 16 * 14); hold(1'b1, 20);
    expect_entry(12'h500, "R5 break");
    chk(obs_q.size() == 0, "R5 single entry", obs_q.size(), 0);
    par_on = 0;

    // R9 disabled at idle, then disabled mid-character
    rx_on = 0;
    send(8'h77, 0, 1, 1);
    expect_none("R9 idle disabled");
    rx_on = 1;
    fork
      send(8'h96, 0, 1, 1);
      begin for (int i = 0; i < 60; i++) on_tick(); rx_on = 0; end
    join
    expect_entry(exp_word(8'h96, 2'b11, 0, 0, 0, 0), "R9 finish char");
    rx_on = 1;

    // R6 overrun
    buf_full = 1;
    send(8'h12, 0, 1, 1);
    expect_none("R6 discarded");
    chk(status[3] == 1'b1, "R6 status ovr", status, 4'h8);
    chk(status[2:0] == 3'b000, "R7 no update on receive", status, 4'h8);
    buf_full = 0;
    send(8'h34, 0, 1, 1);
    expect_entry(exp_word(8'h34, 2'b11, 1, 0, 0, 0), "R6 tagged");
    send(8'h56, 0, 1, 1);
    expect_entry(exp_word(8'h56, 2'b11, 0, 0, 0, 0), "R6 tag once");

    // R7 read-driven update
    do_read(3'b010, 0);
    chk(status == 4'b1010, "R7 read pe", status, 4'b1010);
    do_read(3'b101, 0);
    chk(status == 4'b1101, "R7 read be fe", status, 4'b1101);
    // R8 clear wins over read
    do_read(3'b111, 1);
    chk(status == 4'b0000, "R8 clear", status, 0);

    // R10 flow control
    @(posedge clk); #1; flow_on = 1; buf_full = 1;
    @(posedge clk); @(posedge clk); #1;
    chk(rts_n == 1'b1, "R10 full", rts_n, 1);
    buf_full = 0;
    @(posedge clk); @(posedge clk); #1;
    chk(rts_n == 1'b0, "R10 room", rts_n, 0);
    buf_full = 1; flow_on = 0;
    @(posedge clk); @(posedge clk); #1;
    chk(rts_n == 1'b0, "R10 off", rts_n, 0);
    buf_full = 0;

    // random mix, R1 R3
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      logic bp;
      d = 8'($urandom);
      len_sel = 2'($urandom);
      par_on = 1'($urandom);
      par_even = 1'($urandom);
      par_fix = 1'($urandom);
      bp = par_on && ($urandom % 4 == 0);
      send(d, bp, 1, 1 + int'($urandom % 2));
      expect_entry(exp_word(d, len_sel, 0, 0, bp, 0), "R1 R3 random");
    end

    expect_none("R6 no stray writes");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule